// File: doc/BRIEF.md
# Length-16 Polar Half-Tree Decoder

This block decodes one length-16 polar codeword in a fixed number of cycles. It takes sixteen signed 8-bit channel log-likelihood ratios (LLRs) and a 16-bit mask that marks each bit as information or frozen. The block splits the decoding tree at its root into two length-8 children. It derives the eight LLRs of the left child, decodes that child, re-encodes the result into partial sums, and then uses those sums to derive and decode the right child.

Each child is decoded by one of three routines, chosen from its eight mask bits. A fully frozen child returns zeros with no work. A child with no frozen bits takes a sign decision on each LLR and passes the result through the 8-point polar transform. A child with both kinds of bits is sent to an external learned sub-decoder through a request/response handshake. The handshake stalls the sequence until the response arrives.

The 16 estimated bits appear on the output together with a one-cycle done pulse. A new codeword can be started in the same cycle as that pulse.

Top module: `polar16_halftree_dec`

## Requirements
- R1: Left-child LLR j (j = 0..7) is sign(L_j)·sign(L_{j+8})·min(|L_j|,|L_{j+8}|), where L_j is the 8-bit signed channel LLR at llr_i[8j+7:8j]. The result saturates to [-128, 127], so two inputs of -128 give +127.
- R2: Right-child LLR j is L_{j+8}+L_j when partial sum x_j is 0, and L_{j+8}−L_j when x_j is 1, saturated to [-128, 127]. The partial sums x_0..x_7 are the left child's decoded bits passed through the 8-point polar transform.
- R3: Mask bit 1 marks an information bit and 0 a frozen bit. On a child with no frozen bits, the sign decision is 0 for an LLR ≥ 0 and 1 for an LLR < 0, zero included.
- R4: A child whose eight mask bits are all 0 yields eight zero bits and raises no sub-decoder request.
- R5: A child whose eight mask bits are all 1 yields the sign-decision vector times the 8×8 polar transform over GF(2): output bit c is the XOR of decision bits r over every r whose index bits include all of c's. No request is raised.
- R6: A child with mixed mask bits raises nn_req_o. The request carries the child's LLRs on nn_llr_o (LLR j at bits 8j+7:8j) and its mask on nn_mask_o (bit j). The returned bits are ANDed with the mask, so frozen positions always decode to 0.
- R7: While nn_req_o is high and nn_rsp_valid_i is low, the request and its payload hold steady. Every such cycle delays completion by one cycle.
- R8: With the default two lanes, done_o rises 14 clock edges after the edge that accepts start_i, plus one edge for each stall cycle of R7.
- R9: dec_bits_o[7:0] holds the left child's bits u0..u7 and dec_bits_o[15:8] the right child's bits u8..u15. It changes only in the cycle when done_o is high. done_o lasts one cycle.
- R10: busy_o is high from the accept edge until done. A start_i seen while busy is ignored, and the inputs captured at acceptance are the ones decoded. A start in the done cycle is accepted.
- R11: After a synchronous active-low reset, busy_o, done_o, nn_req_o and dec_bits_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to decode the inputs present this cycle |
| llr_i | input | 128 | Sixteen signed channel LLRs, LLR i at bits 8i+7:8i |
| mask_i | input | 16 | Information mask, bit i = 1 for an information bit |
| busy_o | output | 1 | A decode is in progress |
| done_o | output | 1 | One-cycle pulse: dec_bits_o is new |
| dec_bits_o | output | 16 | Estimated bits, bit i = u_i |
| nn_req_o | output | 1 | Request to the learned sub-decoder |
| nn_llr_o | output | 64 | Child LLRs sent with the request |
| nn_mask_o | output | 8 | Child mask sent with the request |
| nn_rsp_valid_i | input | 1 | Sub-decoder response is valid this cycle |
| nn_rsp_bits_i | input | 8 | Sub-decoder estimated child bits |

## Verification
The decoder is fed masks that send each child down each of the three routes: all-frozen, all-information, and mixed on one or both sides. A wrong route selection or a wrong output half therefore shows up as a bit mismatch. All-information runs with LLRs near zero separate a ≥0 sign decision from a >0 one. Runs with LLRs pinned at -128 and +127 on mixed masks expose the child LLRs on the request payload, which tells saturation apart from wrap-around in both the min-sum and the add/subtract step. The sub-decoder returns ones in frozen positions and answers after varying delays, and start is held high across a whole decode with changing data. These cases separate correct masking, stalling, input capture and back-to-back acceptance from near misses.

// File: rtl/polar16_pkg.sv
// Package for the length-16 polar half-tree decoder.
// Holds the sequencer states, the child routing kinds and the 8-point
// polar transform shared by the child router and the partial-sum stage.
package polar16_pkg;

    localparam int unsigned CHILD_N = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LLR,
        ST_DEC,
        ST_SEL,
        ST_PSUM,
        ST_OUT
    } p16_state_e;

    typedef enum logic [1:0] {
        KIND_ZERO,
        KIND_FULL,
        KIND_MIXED
    } p16_kind_e;

    // Row vector times the third Kronecker power of [[1,0],[1,1]] over GF(2),
    // computed as three butterfly stages (lower index absorbs the upper one).
    function automatic logic [7:0] polar_xform8(input logic [7:0] v);
        logic [7:0] t;
        t = v;
        for (int s = 0; s < 3; s++) begin
            for (int i = 0; i < 8; i++) begin
                if (((i >> s) & 1) == 0) begin
                    t[i] = t[i] ^ t[i + (1 << s)];
                end
            end
        end
        return t;
    endfunction

endpackage

// File: rtl/p16_llr_unit.sv
// One lane of child-LLR arithmetic.
// Computes either the min-sum combination (left child) or the partial-sum
// controlled add/subtract (right child) of two signed LLRs, then saturates
// the result to the LLR width. Purely combinational.
module p16_llr_unit #(
    parameter int LLR_W = 8
) (
    input  logic signed [LLR_W-1:0] a_i,
    input  logic signed [LLR_W-1:0] b_i,
    input  logic                    psum_i,
    input  logic                    use_g_i,
    output logic signed [LLR_W-1:0] y_o
);

    localparam int EXT_W = LLR_W + 2;
    localparam logic signed [EXT_W-1:0] SAT_HI = EXT_W'((2 ** (LLR_W - 1)) - 1);
    localparam logic signed [EXT_W-1:0] SAT_LO = ~SAT_HI;

    logic signed [EXT_W-1:0] ea, eb, mag_a, mag_b, mn, fv, gv, pick;

    // Extended-width arithmetic for both child types, then clamp.
    always_comb begin
        ea    = {{2{a_i[LLR_W-1]}}, a_i};
        eb    = {{2{b_i[LLR_W-1]}}, b_i};
        mag_a = a_i[LLR_W-1] ? -ea : ea;
        mag_b = b_i[LLR_W-1] ? -eb : eb;
        mn    = (mag_a < mag_b) ? mag_a : mag_b;
        fv    = (a_i[LLR_W-1] ^ b_i[LLR_W-1]) ? -mn : mn;
        gv    = psum_i ? (eb - ea) : (eb + ea);
        pick  = use_g_i ? gv : fv;
        if (pick > SAT_HI) begin
            y_o = SAT_HI[LLR_W-1:0];
        end else if (pick < SAT_LO) begin
            y_o = SAT_LO[LLR_W-1:0];
        end else begin
            y_o = pick[LLR_W-1:0];
        end
    end

endmodule

// File: rtl/p16_child_route.sv
// Routing and result selection for one length-8 child.
// Classifies the child from its mask, forms the sign decisions of its LLRs,
// and selects the child's bits: zeros, transformed registered decisions, or
// the registered (already masked) sub-decoder response.
// Assumes hard_q_i and nn_bits_q_i were registered while in the decode state.
module p16_child_route
    import polar16_pkg::*;
#(
    parameter int LLR_W = 8
) (
    input  logic [CHILD_N*LLR_W-1:0] child_llr_i,
    input  logic [CHILD_N-1:0]       child_mask_i,
    input  logic [CHILD_N-1:0]       hard_q_i,
    input  logic [CHILD_N-1:0]       nn_bits_q_i,
    output p16_kind_e                kind_o,
    output logic [CHILD_N-1:0]       hard_o,
    output logic [CHILD_N-1:0]       bits_o
);

    // Sign decision per position: negative LLR gives 1, zero or positive gives 0.
    for (genvar j = 0; j < CHILD_N; j++) begin : g_sign
        assign hard_o[j] = child_llr_i[j*LLR_W + LLR_W - 1];
    end

    // Child kind from how many positions carry information.
    always_comb begin
        if (child_mask_i == '0) begin
            kind_o = KIND_ZERO;
        end else if (&child_mask_i) begin
            kind_o = KIND_FULL;
        end else begin
            kind_o = KIND_MIXED;
        end
    end

    // Result chosen by kind.
    always_comb begin
        unique case (kind_o)
            KIND_ZERO: bits_o = '0;
            KIND_FULL: bits_o = polar_xform8(hard_q_i);
            default:   bits_o = nn_bits_q_i;
        endcase
    end

endmodule

// File: rtl/p16_seq.sv
// Sequencer of the half-tree decoder.
// Walks idle -> child LLRs (GROUPS cycles) -> decode -> select, for the left
// child, then partial sums, then the same for the right child, then output.
// The decode state holds until dec_adv_i is high (sub-decoder handshake).
module p16_seq
    import polar16_pkg::*;
#(
    parameter int GROUPS = 4,
    parameter int GRP_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dec_adv_i,
    output p16_state_e       state_o,
    output logic [GRP_W-1:0] grp_o,
    output logic             side_o,
    output logic             accept_o
);

    p16_state_e       state_q;
    logic [GRP_W-1:0] grp_q;
    logic             side_q;

    assign accept_o = (state_q == ST_IDLE) && start_i;
    assign state_o  = state_q;
    assign grp_o    = grp_q;
    assign side_o   = side_q;

    // State, lane-group counter and child side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grp_q   <= '0;
            side_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_LLR;
                        grp_q   <= '0;
                        side_q  <= 1'b0;
                    end
                end
                ST_LLR: begin
                    if (grp_q == GRP_W'(GROUPS - 1)) begin
                        state_q <= ST_DEC;
                        grp_q   <= '0;
                    end else begin
                        grp_q <= grp_q + 1'b1;
                    end
                end
                ST_DEC: begin
                    if (dec_adv_i) begin
                        state_q <= ST_SEL;
                    end
                end
                ST_SEL: begin
                    state_q <= side_q ? ST_OUT : ST_PSUM;
                end
                ST_PSUM: begin
                    state_q <= ST_LLR;
                    side_q  <= 1'b1;
                    grp_q   <= '0;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/polar16_halftree_dec.sv
// Length-16 polar decoder split at the root into two length-8 children.
// Captures LLRs and mask on start, forms child LLRs LANES at a time, routes
// each child to a zero shortcut, a sign-decision-plus-transform path or an
// external learned sub-decoder, and emits the 16 bits with a done pulse.
// Assumes LANES divides 8. Latency is 2*(8/LANES)+6 edges plus stall cycles.
module polar16_halftree_dec
    import polar16_pkg::*;
#(
    parameter int LLR_W = 8,
    parameter int LANES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [16*LLR_W-1:0]      llr_i,
    input  logic [15:0]              mask_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [15:0]              dec_bits_o,
    output logic                     nn_req_o,
    output logic [8*LLR_W-1:0]       nn_llr_o,
    output logic [7:0]               nn_mask_o,
    input  logic                     nn_rsp_valid_i,
    input  logic [7:0]               nn_rsp_bits_i
);

    localparam int N       = 16;
    localparam int HALF    = N / 2;
    localparam int GROUPS  = HALF / LANES;
    localparam int GRP_W   = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam int IDX_W   = $clog2(HALF);
    localparam int LATENCY = 2 * GROUPS + 6;

    p16_state_e              state;
    logic [GRP_W-1:0]        grp;
    logic                    side;
    logic                    accept;
    logic                    dec_adv;
    p16_kind_e               kind;

    logic signed [LLR_W-1:0] llr_q   [N];
    logic [N-1:0]            mask_q;
    logic signed [LLR_W-1:0] child_q [HALF];
    logic [HALF*LLR_W-1:0]   child_flat;
    logic [HALF-1:0]         child_mask;
    logic [HALF-1:0]         hard_now, hard_q;
    logic [HALF-1:0]         nn_bits_q;
    logic [HALF-1:0]         sel_bits;
    logic [HALF-1:0]         left_q, right_q;
    logic [HALF-1:0]         psum_q;

    logic [IDX_W-1:0]        lane_idx [LANES];
    logic signed [LLR_W-1:0] lane_y   [LANES];

    p16_seq #(
        .GROUPS (GROUPS),
        .GRP_W  (GRP_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .dec_adv_i (dec_adv),
        .state_o   (state),
        .grp_o     (grp),
        .side_o    (side),
        .accept_o  (accept)
    );

    // Lanes working on the current group of child positions.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_idx[k] = IDX_W'(int'(grp) * LANES + k);
        p16_llr_unit #(
            .LLR_W (LLR_W)
        ) u_unit (
            .a_i     (llr_q[{1'b0, lane_idx[k]}]),
            .b_i     (llr_q[{1'b1, lane_idx[k]}]),
            .psum_i  (psum_q[lane_idx[k]]),
            .use_g_i (side),
            .y_o     (lane_y[k])
        );
    end

    for (genvar j = 0; j < HALF; j++) begin : g_flat
        assign child_flat[j*LLR_W +: LLR_W] = child_q[j];
    end

    assign child_mask = side ? mask_q[N-1:HALF] : mask_q[HALF-1:0];

    p16_child_route #(
        .LLR_W (LLR_W)
    ) u_route (
        .child_llr_i  (child_flat),
        .child_mask_i (child_mask),
        .hard_q_i     (hard_q),
        .nn_bits_q_i  (nn_bits_q),
        .kind_o       (kind),
        .hard_o       (hard_now),
        .bits_o       (sel_bits)
    );

    assign dec_adv   = (kind != KIND_MIXED) || nn_rsp_valid_i;
    assign nn_req_o  = (state == ST_DEC) && (kind == KIND_MIXED);
    assign nn_llr_o  = child_flat;
    assign nn_mask_o = child_mask;
    assign busy_o    = (state != ST_IDLE);

    // Capture channel LLRs and mask when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) llr_q[i] <= '0;
            mask_q <= '0;
        end else if (accept) begin
            for (int i = 0; i < N; i++) llr_q[i] <= llr_i[i*LLR_W +: LLR_W];
            mask_q <= mask_i;
        end
    end

    // Write LANES child LLRs per cycle during the LLR state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < HALF; j++) child_q[j] <= '0;
        end else if (state == ST_LLR) begin
            for (int k = 0; k < LANES; k++) child_q[lane_idx[k]] <= lane_y[k];
        end
    end

    // Register sign decisions and the masked sub-decoder response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hard_q    <= '0;
            nn_bits_q <= '0;
        end else if (state == ST_DEC) begin
            hard_q <= hard_now;
            if (nn_rsp_valid_i) begin
                nn_bits_q <= nn_rsp_bits_i & child_mask;
            end
        end
    end

    // Store each child's selected bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            right_q <= '0;
        end else if (state == ST_SEL) begin
            if (side) right_q <= sel_bits;
            else      left_q  <= sel_bits;
        end
    end

    // Re-encode the left child into partial sums for the right child.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psum_q <= '0;
        end else if (state == ST_PSUM) begin
            psum_q <= polar_xform8(left_q);
        end
    end

    // Publish the codeword estimate with a one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_bits_o <= '0;
            done_o     <= 1'b0;
        end else begin
            done_o <= (state == ST_OUT);
            if (state == ST_OUT) begin
                dec_bits_o <= {right_q, left_q};
            end
        end
    end

endmodule

// File: rtl/p16_checker.sv
// Protocol and timing checks for polar16_halftree_dec, attached by bind.
// Counts non-stalled busy cycles from acceptance to check the latency.
module p16_checker #(
    parameter int LLR_W = 8,
    parameter int LAT   = 14
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [15:0]        dec_bits_o,
    input logic               nn_req_o,
    input logic               nn_rsp_valid_i,
    input logic [8*LLR_W-1:0] nn_llr_o,
    input logic [7:0]         nn_mask_o,
    input logic [15:0]        cap_mask
);

    logic [15:0] run_cnt;

    // Cycles of progress since the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!busy_o && start_i) begin
            run_cnt <= '0;
        end else if (busy_o && !(nn_req_o && !nn_rsp_valid_i)) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_cnt == 16'(LAT)));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(dec_bits_o));

    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (nn_req_o && !nn_rsp_valid_i) |=>
            (nn_req_o && $stable(nn_llr_o) && $stable(nn_mask_o)));

    a_r6_req_mixed: assert property (@(posedge clk) disable iff (!rst_n)
        nn_req_o |-> (busy_o && (nn_mask_o != 8'h00) && (nn_mask_o != 8'hFF)));

    a_r6_frozen_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((dec_bits_o & ~cap_mask) == 16'h0000));

    a_r10_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(cap_mask));

    a_r11_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && !nn_req_o));

endmodule

bind polar16_halftree_dec p16_checker #(
    .LLR_W (LLR_W),
    .LAT   (LATENCY)
) u_p16_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .dec_bits_o     (dec_bits_o),
    .nn_req_o       (nn_req_o),
    .nn_rsp_valid_i (nn_rsp_valid_i),
    .nn_llr_o       (nn_llr_o),
    .nn_mask_o      (nn_mask_o),
    .cap_mask       (mask_q)
);

// File: tb/polar16_halftree_dec_bench.sv
`timescale 1ns/1ps
// Bench for polar16_halftree_dec: behavioural reference model stepped on
// every rising edge, outputs compared on every falling edge.
module polar16_halftree_dec_bench;

    localparam int LLR_W   = 8;
    localparam int LAT_REF = 14;
    localparam int POS_LDEC = 4;
    localparam int POS_RDEC = 11;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] llr_i;
    logic [15:0]  mask_i = '0;
    logic         busy_o, done_o, nn_req_o;
    logic [15:0]  dec_bits_o;
    logic [63:0]  nn_llr_o;
    logic [7:0]   nn_mask_o;
    logic         nn_rsp_valid_i = 1'b0;
    logic [7:0]   nn_rsp_bits_i = '0;

    int cur_llr [16];
    logic [7:0] rsp_l = '0, rsp_r = '0;
    int rsp_delay = 0;
    int wait_cnt = 0;
    string cur_req = "R11";

    int checks = 0, failures = 0, cyc = 0, req_seen = 0;

    // reference model state
    bit         m_busy = 0, m_done = 0, m_lmix = 0, m_rmix = 0;
    int         m_pos = 0;
    logic [15:0] m_bits = '0, m_exp = '0;
    logic [7:0] m_lmask = '0, m_rmask = '0;
    int         m_cl [8];
    int         m_cr [8];

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 16; i++) llr_i[i*8 +: 8] = cur_llr[i][7:0];
    end

    polar16_halftree_dec u_polar16_halftree_dec (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .llr_i(llr_i), .mask_i(mask_i),
        .busy_o(busy_o), .done_o(done_o), .dec_bits_o(dec_bits_o),
        .nn_req_o(nn_req_o), .nn_llr_o(nn_llr_o), .nn_mask_o(nn_mask_o),
        .nn_rsp_valid_i(nn_rsp_valid_i), .nn_rsp_bits_i(nn_rsp_bits_i)
    );

    function automatic int sat8(int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    function automatic int fref(int a, int b);
        int ma, mb, m;
        ma = (a < 0) ? -a : a;
        mb = (b < 0) ? -b : b;
        m = (ma < mb) ? ma : mb;
        return sat8(((a < 0) != (b < 0)) ? -m : m);
    endfunction

    function automatic int gref(int a, int b, bit x);
        return sat8(x ? (b - a) : (b + a));
    endfunction

    // Matrix form: out[c] = XOR of x[r] for every r whose bits cover c.
    function automatic logic [7:0] xref(logic [7:0] x);
        logic [7:0] o;
        o = '0;
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 8; r++)
                if ((c & ~r & 7) == 0) o[c] = o[c] ^ x[r];
        return o;
    endfunction

    function automatic logic [7:0] child_ref(int l[8], logic [7:0] m, logic [7:0] rsp);
        logic [7:0] h;
        if (m == 8'h00) return 8'h00;
        if (m == 8'hFF) begin
            for (int i = 0; i < 8; i++) h[i] = (l[i] < 0);
            return xref(h);
        end
        return rsp & m;
    endfunction

    function automatic bit exp_req();
        return m_busy && ((m_pos == POS_LDEC && m_lmix) || (m_pos == POS_RDEC && m_rmix));
    endfunction

    task automatic model_accept();
        logic [7:0] lb, rb, ps;
        for (int i = 0; i < 8; i++) m_cl[i] = fref(cur_llr[i], cur_llr[i+8]);
        m_lmask = mask_i[7:0];
        m_rmask = mask_i[15:8];
        lb = child_ref(m_cl, m_lmask, rsp_l);
        ps = xref(lb);
        for (int i = 0; i < 8; i++) m_cr[i] = gref(cur_llr[i], cur_llr[i+8], ps[i]);
        rb = child_ref(m_cr, m_rmask, rsp_r);
        m_exp  = {rb, lb};
        m_lmix = (m_lmask != 8'h00) && (m_lmask != 8'hFF);
        m_rmix = (m_rmask != 8'h00) && (m_rmask != 8'hFF);
    endtask

    // Reference model step at each rising edge.
    always @(posedge clk) begin
        bit stall;
        if (!rst_n) begin
            m_busy = 0; m_pos = 0; m_done = 0; m_bits = '0;
        end else begin
            m_done = 0;
            if (!m_busy) begin
                if (start_i) begin
                    model_accept();
                    m_busy = 1;
                    m_pos = 0;
                end
            end else begin
                stall = exp_req() && !nn_rsp_valid_i;
                if (!stall) begin
                    m_pos++;
                    if (m_pos == LAT_REF) begin
                        m_busy = 0; m_done = 1; m_bits = m_exp;
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Per-cycle compare, then the sub-decoder responder.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(0, "WATCHDOG", "run did not end", cyc, 150000);
            finish_run();
        end
        check(busy_o == m_busy, "R10", "busy_o", busy_o, m_busy);
        check(done_o == m_done, "R8", "done_o", done_o, m_done);
        check(dec_bits_o == m_bits, (m_done ? cur_req : "R9"), "dec_bits_o", dec_bits_o, m_bits);
        check(nn_req_o == exp_req(), "R6", "nn_req_o", nn_req_o, exp_req());
        if (nn_req_o) req_seen++;
        if (nn_req_o && exp_req()) begin
            check(nn_mask_o == ((m_pos < 7) ? m_lmask : m_rmask), "R6", "nn_mask_o",
                  nn_mask_o, (m_pos < 7) ? m_lmask : m_rmask);
            for (int j = 0; j < 8; j++) begin
                int e;
                e = (m_pos < 7) ? m_cl[j] : m_cr[j];
                check($signed(nn_llr_o[j*8 +: 8]) == e, (m_pos < 7) ? "R1" : "R2",
                      "child llr", $signed(nn_llr_o[j*8 +: 8]), e);
            end
        end
        if (nn_req_o) begin
            if (wait_cnt >= rsp_delay) begin
                nn_rsp_valid_i = 1'b1;
                nn_rsp_bits_i  = (m_pos < 7) ? rsp_l : rsp_r;
            end else begin
                nn_rsp_valid_i = 1'b0;
                wait_cnt++;
            end
        end else begin
            nn_rsp_valid_i = 1'b0;
            wait_cnt = 0;
        end
    end

    task automatic load(input int seed_mode, input int base);
        for (int i = 0; i < 16; i++) begin
            case (seed_mode)
                0: cur_llr[i] = int'($urandom_range(255)) - 128;
                1: cur_llr[i] = (i % 3) - 1;
                default: cur_llr[i] = base;
            endcase
        end
    endtask

    task automatic run(input logic [15:0] mask, input logic [7:0] rl, input logic [7:0] rr,
                       input int dly, input string tag);
        int n, stalls;
        @(negedge clk);
        mask_i = mask; rsp_l = rl; rsp_r = rr; rsp_delay = dly; cur_req = tag;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        stalls = dly * (int'(m_lmix) + int'(m_rmix));
        n = 0;
        while (m_busy) begin
            @(negedge clk);
            n++;
        end
        check(n == LAT_REF + stalls, "R8", "latency", n, LAT_REF + stalls);
        check(dec_bits_o == m_exp, tag, "result", dec_bits_o, m_exp);
    endtask

    initial begin
        load(0, 0);
        repeat (3) @(negedge clk);
        // R11: reset state
        check(busy_o == 0 && done_o == 0 && nn_req_o == 0 && dec_bits_o == 0, "R11",
              "reset outputs", {busy_o, done_o, nn_req_o}, 0);
        rst_n = 1'b1;

        // R4: fully frozen codeword, no request
        load(0, 0);
        req_seen = 0;
        run(16'h0000, 8'hFF, 8'hFF, 0, "R4");
        check(req_seen == 0, "R4", "requests", req_seen, 0);

        // R5: all information
        load(0, 0);
        run(16'hFFFF, 8'h00, 8'h00, 0, "R5");
        load(0, 0);
        run(16'hFFFF, 8'h00, 8'h00, 0, "R5");

        // R3: LLRs at -1, 0, +1
        load(1, 0);
        run(16'hFFFF, 8'h00, 8'h00, 0, "R3");
        load(2, 0);
        run(16'hFFFF, 8'h00, 8'h00, 0, "R3");

        // R6: both children mixed, responder sets frozen positions too
        load(0, 0);
        run(16'h17E8, 8'hFF, 8'hFF, 0, "R6");
        load(0, 0);
        run(16'h3C81, 8'hA5, 8'h5A, 0, "R6");

        // R7: delayed responses stall the sequence
        load(0, 0);
        run(16'h17E8, 8'h3C, 8'hC3, 3, "R7");

        // R1/R2: saturation on both children, payload visible on requests
        load(2, -128);
        run(16'h7E7E, 8'hFF, 8'hFF, 0, "R1");
        load(2, 127);
        run(16'h7E7E, 8'h00, 8'hFF, 1, "R2");
        load(2, -128);
        run(16'hFFFF, 8'h00, 8'h00, 0, "R1");
        for (int i = 0; i < 8; i++) begin cur_llr[i] = 127; cur_llr[i+8] = 127; end
        run(16'hFFFF, 8'h00, 8'h00, 0, "R2");

        // R4/R5: one child per shortcut
        load(0, 0);
        run(16'hFF00, 8'h00, 8'h00, 0, "R5");
        load(0, 0);
        run(16'h00FF, 8'h00, 8'h00, 0, "R4");

        // R10: start held high, data changed while busy, restart in done cycle
        load(0, 0);
        @(negedge clk);
        mask_i = 16'hE817; rsp_l = 8'h96; rsp_r = 8'h69; rsp_delay = 1; cur_req = "R10";
        start_i = 1'b1;
        @(negedge clk);
        load(0, 0);
        mask_i = 16'hFFFF;
        while (m_busy) @(negedge clk);
        check(dec_bits_o == m_bits && done_o, "R10", "first result under held start",
              dec_bits_o, m_bits);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R10", "restart in done cycle", busy_o, 1);
        while (m_busy) @(negedge clk);
        check(dec_bits_o == m_exp, "R10", "second result", dec_bits_o, m_exp);

        // R9: random masks and delays
        for (int t = 0; t < 24; t++) begin
            load(0, 0);
            run(16'($urandom), 8'($urandom), 8'($urandom), int'($urandom_range(2)), "R9");
        end

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule